// File: doc/BRIEF.md
# Keyed Write Guard for Configuration Registers

This block sits on a register bus beside a group of configuration registers: the time word, the date word, the control word, the word holding the initialisation-request bit, the prescaler word and the alarm word. It keeps those registers from being changed by a stray write. Software opens the guard by writing two key bytes, 0xCA and then 0x53, to one key address. While the guard is open, the block passes each bus write aimed at a guarded register on as a one-cycle write strobe for that register. Any other value written to the key address closes the guard again.

The block watches the write strobe, the address and the data of the bus write port. It has three named states. `GS_LOCKED` is the reset state. `GS_FIRST_KEY` means the first key byte has been seen. `GS_OPEN` means guarded writes are allowed. It has five named transitions. `T_KEY_A` goes from LOCKED to FIRST_KEY. `T_KEY_B` goes from FIRST_KEY to OPEN. `T_ABORT` goes from FIRST_KEY to LOCKED on any other value. `T_RELOCK` goes from OPEN to LOCKED on any key write. `T_HOLD` keeps the state on every cycle without a key write.

Software is expected to open the guard just before a guarded update and to close it just after. A write to a guarded register while the guard is not open produces no strobe, so the register keeps its contents.

Top module: `wguard_top`

## Requirements
- R1: While reset is asserted, and after it, the block is in GS_LOCKED: `unlocked` is 0 and `prot_we` is all zeros. An asynchronous reset while open closes the guard.
- R2: In GS_LOCKED, a key write whose low byte is 0xCA moves the block to GS_FIRST_KEY. A key write with any other low byte leaves it in GS_LOCKED, so a later 0x53 does not open the guard.
- R3: In GS_FIRST_KEY, a key write whose low byte is 0x53 moves the block to GS_OPEN. `unlocked` reads 1 from the cycle after that write.
- R4: In GS_FIRST_KEY, a key write with any other low byte returns the block to GS_LOCKED. This includes a repeated 0xCA, so a following 0x53 leaves the guard closed.
- R5: In GS_OPEN, a key write of any value closes the guard (GS_LOCKED). This includes 0xFF, 0xCA and 0x53. A 0x53 written after such a relock does not reopen it.
- R6: Only bits [7:0] of a key write are compared with the key bytes. Bits above bit 7 have no effect on the sequence.
- R7: Cycles without `wr_en`, and writes to any address other than the key address, leave the state unchanged. A guarded write placed between the two key bytes does not break the sequence.
- R8: In GS_OPEN, a write to address PROT_BASE + 4*i (i = 0 time, 1 date, 2 control, 3 init-request word, 4 prescaler, 5 alarm; defaults 0x00..0x14) raises `prot_we[i]` in the same cycle as `wr_en`. The first guarded write can be made in the cycle right after the 0x53 key write.
- R9: While not in GS_OPEN, writes to guarded addresses raise no bit of `prot_we`. The write is dropped.
- R10: At most one `prot_we` bit is high at a time. Addresses outside the guarded set raise no bit, and that includes the key address (default 0x1C) and unaligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW (8) | Byte address of the write |
| wr_data | input | DW (32) | Write data; for key writes only bits [7:0] are compared |
| unlocked | output | 1 | High while the guard is in GS_OPEN |
| prot_we | output | NPROT (6) | Qualified write strobe, one bit per guarded register |

## Verification
On every cycle, the assertions check each state transition of the key machine:
- T_KEY_A, T_KEY_B, T_ABORT and T_RELOCK take effect one cycle after a key write.
- T_HOLD keeps the state stable across non-key cycles.
- `prot_we` is zero whenever the guard is not open.
- `prot_we` is never more than one-hot.

Only the bench scenarios can show the full sequences: a wrong byte or a repeated 0xCA that forces a restart, and a relock that needs a fresh key pair. The scenarios also cover key bytes carried with junk upper bits, guarded writes placed between the keys, the exact strobe mapping for each guarded address, and a reset that closes an open guard.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

    typedef enum logic [1:0] {
        GS_LOCKED    = 2'd0,
        GS_FIRST_KEY = 2'd1,
        GS_OPEN      = 2'd2
    } guard_state_e;

    // Register word spacing on the bus
    localparam int unsigned WORD_STRIDE = 4;
    // Width of the compared key field
    localparam int unsigned KEY_W = 8;

endpackage

// File: rtl/wguard_key_detect.sv
module wguard_key_detect #(
    parameter int unsigned          AW       = 8,
    parameter int unsigned          DW       = 32,
    parameter logic [AW-1:0]        KEY_ADDR = 8'h1C,
    parameter logic [7:0]           KEY_A    = 8'hCA,
    parameter logic [7:0]           KEY_B    = 8'h53
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          key_wr,
    output logic          byte_is_a,
    output logic          byte_is_b
);
    import wguard_pkg::*;

    logic [KEY_W-1:0] key_byte;
    // Upper data bits take no part in key matching (R6)
    logic unused_upper;

    assign key_byte     = wr_data[KEY_W-1:0];
    assign unused_upper = &{1'b0, wr_data[DW-1:KEY_W]};

    always_comb begin
        key_wr    = wr_en && (wr_addr == KEY_ADDR);
        byte_is_a = (key_byte == KEY_A);
        byte_is_b = (key_byte == KEY_B);
    end

endmodule

// File: rtl/wguard_key_fsm.sv
module wguard_key_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     key_wr,
    input  logic                     byte_is_a,
    input  logic                     byte_is_b,
    output wguard_pkg::guard_state_e state_q,
    output logic                     open_o
);
    import wguard_pkg::*;

    guard_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;                        // T_HOLD
        if (key_wr) begin
            unique case (state_q)
                GS_LOCKED:    state_d = byte_is_a ? GS_FIRST_KEY : GS_LOCKED;  // T_KEY_A
                GS_FIRST_KEY: state_d = byte_is_b ? GS_OPEN : GS_LOCKED;       // T_KEY_B / T_ABORT
                GS_OPEN:      state_d = GS_LOCKED;                             // T_RELOCK
                default:      state_d = GS_LOCKED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        open_o = 1'b0;
        unique case (state_q)
            GS_LOCKED:    open_o = 1'b0;
            GS_FIRST_KEY: open_o = 1'b0;
            GS_OPEN:      open_o = 1'b1;
            default:      open_o = 1'b0;
        endcase
    end

    a_r2_first_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_LOCKED && key_wr && byte_is_a) |=> state_q == GS_FIRST_KEY);

    a_r2_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_LOCKED && key_wr && !byte_is_a) |=> state_q == GS_LOCKED);

    a_r3_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_FIRST_KEY && key_wr && byte_is_b) |=> open_o);

    a_r4_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_FIRST_KEY && key_wr && !byte_is_b) |=> state_q == GS_LOCKED);

    a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_OPEN && key_wr) |=> state_q == GS_LOCKED);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(state_q));

    a_r3_open_only_via_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(state_q) == GS_FIRST_KEY);

endmodule

// File: rtl/wguard_prot_decode.sv
module wguard_prot_decode #(
    parameter int unsigned   AW        = 8,
    parameter int unsigned   NPROT     = 6,
    parameter logic [AW-1:0] PROT_BASE = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic             open_i,
    output logic [NPROT-1:0] prot_we
);
    import wguard_pkg::*;

    logic [NPROT-1:0] addr_hit;

    for (genvar i = 0; i < NPROT; i++) begin : g_reg
        localparam logic [AW-1:0] REG_ADDR = AW'(PROT_BASE + i * WORD_STRIDE);
        assign addr_hit[i] = wr_en && (wr_addr == REG_ADDR);
    end

    assign prot_we = open_i ? addr_hit : '0;

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prot_we));

    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && wr_en && wr_addr == PROT_BASE) |-> prot_we[0]);

endmodule

// File: rtl/wguard_top.sv
module wguard_top #(
    parameter int unsigned   AW        = 8,
    parameter int unsigned   DW        = 32,
    parameter int unsigned   NPROT     = 6,
    parameter logic [AW-1:0] PROT_BASE = 8'h00,
    parameter logic [AW-1:0] KEY_ADDR  = 8'h1C,
    parameter logic [7:0]    KEY_A     = 8'hCA,
    parameter logic [7:0]    KEY_B     = 8'h53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic             unlocked,
    output logic [NPROT-1:0] prot_we
);
    import wguard_pkg::*;

    logic         key_wr;
    logic         byte_is_a;
    logic         byte_is_b;
    logic         open_s;
    guard_state_e state_s;

    wguard_key_detect #(
        .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_detect (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .key_wr   (key_wr),
        .byte_is_a(byte_is_a),
        .byte_is_b(byte_is_b)
    );

    wguard_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .byte_is_a(byte_is_a),
        .byte_is_b(byte_is_b),
        .state_q  (state_s),
        .open_o   (open_s)
    );

    wguard_prot_decode #(
        .AW(AW), .NPROT(NPROT), .PROT_BASE(PROT_BASE)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .open_i (open_s),
        .prot_we(prot_we)
    );

    assign unlocked = open_s;

    a_r9_drop_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_s != GS_OPEN) |-> prot_we == '0);

    a_r1_closed_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !unlocked);

endmodule

// File: tb/sim_wguard_top.sv
module sim_wguard_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NPROT = 6;
    localparam logic [7:0] KEY = 8'h1C;

    typedef struct {
        logic [NPROT-1:0] we;
        logic             unl;
        string            tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic unlocked;
    logic [NPROT-1:0] prot_we;

    int checks = 0;
    int errors = 0;
    int ms = 0;          // model: 0 locked, 1 first key, 2 open
    bit go = 0;
    bit done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wguard_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unlocked(unlocked), .prot_we(prot_we)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one bus cycle, with the expected result pushed to the scoreboard
    task automatic cyc(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        e.we = '0;
        if (we && ms == 2 && a[1:0] == 2'b00 && a < 8'(NPROT * 4))
            e.we[a >> 2] = 1'b1;
        if (we && a == KEY) begin
            case (ms)
                0: ms = (d[7:0] == 8'hCA) ? 1 : 0;
                1: ms = (d[7:0] == 8'h53) ? 2 : 0;
                default: ms = 0;
            endcase
        end
        e.unl = (ms == 2);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic key(input logic [DW-1:0] d, input string tag);
        cyc(1, KEY, d, tag);
    endtask

    // Monitor: strobe just before the edge, unlocked just after it
    initial begin
        exp_t e;
        wait (go);
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(prot_we == e.we, e.tag, "prot_we", 32'(prot_we), 32'(e.we));
                @(posedge clk);
                #(CLK_PERIOD/4);
                chk(unlocked == e.unl, e.tag, "unlocked", 32'(unlocked), 32'(e.unl));
            end
        end
    end

    initial begin
        // R1: reset state, with a guarded write attempted during reset
        wr_en = 1; wr_addr = 8'h08; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk(unlocked == 0, "R1", "unlocked in reset", 32'(unlocked), 0);
        chk(prot_we == 0, "R1", "prot_we in reset", 32'(prot_we), 0);
        wr_en = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(unlocked == 0, "R1", "unlocked after reset", 32'(unlocked), 0);
        go = 1;

        cyc(1, 8'h08, 32'h1, "R9");              // locked: dropped
        key(32'hCA, "R2"); key(32'h53, "R3");     // open
        for (int i = 0; i < NPROT; i++) cyc(1, 8'(i * 4), 32'(i), "R8");
        cyc(1, 8'h18, 32'h0, "R10"); cyc(1, 8'h05, 32'h0, "R10");
        cyc(1, KEY, 32'h0, "R10");               // key address gives no strobe; also relocks
        key(32'hCA, "R2"); key(32'h53, "R3");
        cyc(0, 8'h10, 32'h0, "R7"); cyc(1, 8'h10, 32'h7, "R7");
        key(32'hFF, "R5"); cyc(1, 8'h14, 32'h1, "R9");
        key(32'hCA, "R4"); key(32'hCA, "R4"); key(32'h53, "R4");
        key(32'hCA, "R4"); key(32'h12, "R4"); key(32'h53, "R4");
        key(32'h12, "R2"); key(32'h53, "R2");
        key(32'hCA, "R7"); cyc(1, 8'h00, 32'h9, "R7"); cyc(0, 0, 0, "R7");
        key(32'h53, "R7"); cyc(1, 8'h0C, 32'h1, "R8");
        key(32'hCA, "R5"); key(32'h53, "R5");    // relock with 0xCA, then 0x53 stays closed
        key(32'hCA, "R5"); key(32'h53, "R5"); key(32'h53, "R5");
        key(32'hFFFF_FFCA, "R6"); key(32'h1234_5653, "R6");
        cyc(1, 8'h04, 32'h2, "R6");
        key(32'h0000_CA00, "R6");                // low byte 0x00 relocks
        cyc(1, 8'h04, 32'h2, "R6");
        cyc(0, 0, 0, "R7");
        wait (q.size() == 0);
        @(posedge clk); #(CLK_PERIOD/2);

        // R1: asynchronous reset closes an open guard
        go = 0;
        key(32'hCA, "R1"); key(32'h53, "R1");
        @(negedge clk); wr_en = 0;
        q.delete();
        chk(unlocked == 1, "R1", "open before reset", 32'(unlocked), 1);
        #(CLK_PERIOD/4); rst_n = 0; #1;
        chk(unlocked == 0, "R1", "closed by reset", 32'(unlocked), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule